// File: doc/BRIEF.md
# Start frame recognizer

This block sits beside an asynchronous serial receiver and decides when a start frame has arrived, so that the payload that follows may be handled. A start frame has up to three parts, in this order: a break, during which the receive line is held low for a long time; a first control byte; and a second control byte. The second byte is always present. The break and the first byte can each be left out through two configuration inputs, which gives four frame shapes.

The raw receive line passes through a synchronizer and feeds a prescaled low-time counter. The line counts as a break once it has stayed low for a programmed number of prescaled periods. Received bytes arrive from the external bit sampler as single-cycle valid strobes. The first control byte must equal one programmed value. The second must equal either a primary or a secondary value. A failed comparison returns the block, without any flag, to the stage where the frame begins, so a fresh frame is needed. Each stage that succeeds sets a sticky flag, which is cleared by writing one to it. It also emits an interrupt pulse that can be masked. Once the second byte matches, the block raises a payload-permitted level. That level stays high until software arms the block again.

Top module: `sfrm_top`

## Requirements
- R1: After reset every flag, interrupt, `line_low_st` and `payload_go` is 0 and the block is idle: bytes and line activity are ignored until `arm` is pulsed.
- R2: An `arm` pulse, in any state, restarts recognition at the first enabled stage. That stage is the break if `brk_en`=1, otherwise the first control byte if `cf0_en`=1, otherwise the second control byte.
- R3: While a break is awaited, the break is detected when the synchronized line (two flops of delay) is low and the low-period count is at least `brk_count`. One period is `brk_presc`+1 low samples. The counter saturates at its maximum value. Detection sets `flag_brk`, and it pulses `irq_brk` for one cycle if `ie_brk`=1.
- R4: Any high sample of the synchronized line clears the low-time count, so short low pulses never add up to a break.
- R5: From break detection until the synchronized line is sampled high, `line_low_st` is 1. When the line is sampled high, `line_low_st` returns to 0 and the block waits for the first control byte, or for the second byte if `cf0_en`=0.
- R6: A first control byte equal to `cf0_val` sets `flag_cf0`, pulses `irq_cf` if `ie_cf0`=1, and moves the block to the second byte.
- R7: A first control byte that differs from `cf0_val` sets no flag and returns the block to the first enabled stage. A following byte is then not taken as the second byte.
- R8: A second control byte equal to `cf1_pri` or to `cf1_sec` sets `flag_cf1`, pulses `irq_cf` if `ie_cf1`=1, and raises `payload_go`, which stays 1 until the next `arm`.
- R9: A second control byte that matches neither value sets no flag and returns the block to the first enabled stage.
- R10: The bits of `flag_clr` clear the flags: bit 0 clears `flag_brk`, bit 1 clears `flag_cf0` and bit 2 clears `flag_cf1`. A flag set in the same cycle stays set.
- R11: Byte strobes are ignored while the block waits for a break, while it holds `line_low_st`, and after `payload_go` is raised.
- R12: With an interrupt enable at 0, its interrupt stays 0, and the matching flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial receive line, idle high |
| arm | input | 1 | Start-detect strobe, restarts recognition |
| brk_en | input | 1 | Frame begins with a break |
| cf0_en | input | 1 | Frame contains the first control byte |
| brk_count | input | CNT_W | Break length in prescaled periods |
| brk_presc | input | PRE_W | Prescaler: a period is this value + 1 cycles |
| cf0_val | input | 8 | Compare value for the first control byte |
| cf1_pri | input | 8 | Primary compare value for the second byte |
| cf1_sec | input | 8 | Secondary compare value for the second byte |
| byte_valid | input | 1 | Received byte strobe from the bit sampler |
| byte_data | input | 8 | Received byte |
| ie_brk | input | 1 | Break interrupt enable |
| ie_cf0 | input | 1 | First-byte match interrupt enable |
| ie_cf1 | input | 1 | Second-byte match interrupt enable |
| flag_clr | input | 3 | Write-one-to-clear strobes for the flags |
| flag_brk | output | 1 | Break detected flag |
| flag_cf0 | output | 1 | First control byte matched flag |
| flag_cf1 | output | 1 | Second control byte matched flag |
| irq_brk | output | 1 | Break interrupt pulse |
| irq_cf | output | 1 | Control byte match interrupt pulse |
| line_low_st | output | 1 | Break seen, line still low |
| payload_go | output | 1 | Payload transfer permitted |

## Verification
The bench drives trains of short low pulses split by single high gaps. A design that let the low count survive a high sample would report a break there, and one that is off by one register in the count would flag it a cycle early or late against the cycle model. Mismatching first and second bytes are each followed at once by a byte that would match the next stage. A design that did not fall back to the first stage would then grant payload. Bytes sent while a break is awaited, and all four frame shapes, are also checked against the model, as are interrupts with the enables at 0, which expose a design that sends unmasked pulses or fails to set its flags.

// File: rtl/sfrm_pkg.sv
package sfrm_pkg;

    localparam int BYTE_W = 8;
    localparam int N_FLAG = 3;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WBRK = 3'd1,
        ST_BLOW = 3'd2,
        ST_CF0  = 3'd3,
        ST_CF1  = 3'd4,
        ST_PAY  = 3'd5
    } sfrm_state_e;

    typedef struct packed {
        logic cf1;
        logic cf0;
        logic brk;
    } sfrm_evt_t;

    function automatic sfrm_state_e first_stage(input logic brk_en, input logic cf0_en);
        if (brk_en)
            return ST_WBRK;
        else if (cf0_en)
            return ST_CF0;
        else
            return ST_CF1;
    endfunction

endpackage

// File: rtl/sfrm_sync.sv
module sfrm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '1;
        else
            chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sfrm_brk_timer.sv
module sfrm_brk_timer #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_s,
    input  logic [PRE_W-1:0] presc,
    output logic [CNT_W-1:0] low_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || line_s) begin
            pre_q   <= '0;
            low_cnt <= '0;
        end else if (pre_q == presc) begin
            pre_q <= '0;
            if (low_cnt != CNT_MAX)
                low_cnt <= low_cnt + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (!line_s && low_cnt == CNT_MAX) |=> (low_cnt == CNT_MAX)); // R3

    AST_HIGH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        line_s |=> (low_cnt == '0)); // R4
endmodule

// File: rtl/sfrm_seq.sv
module sfrm_seq
    import sfrm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              brk_en,
    input  logic              cf0_en,
    input  logic              line_s,
    input  logic [CNT_W-1:0]  low_cnt,
    input  logic [CNT_W-1:0]  brk_count,
    input  logic [BYTE_W-1:0] cf0_val,
    input  logic [BYTE_W-1:0] cf1_pri,
    input  logic [BYTE_W-1:0] cf1_sec,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output sfrm_evt_t         evt,
    output logic              line_low_st,
    output logic              payload_go
);
    sfrm_state_e state_q, state_d;
    sfrm_state_e restart;

    logic [BYTE_W-1:0] cf1_ref [2];
    logic [1:0]        cf1_hit;

    assign cf1_ref[0] = cf1_pri;
    assign cf1_ref[1] = cf1_sec;

    for (genvar g = 0; g < 2; g++) begin : g_cf1_cmp
        assign cf1_hit[g] = (byte_data == cf1_ref[g]);
    end

    assign restart = first_stage(brk_en, cf0_en);

    always_comb begin
        state_d = state_q;
        evt     = '0;
        if (arm) begin
            state_d = restart;
        end else begin
            case (state_q)
                ST_WBRK: begin
                    if (!line_s && (low_cnt >= brk_count)) begin
                        evt.brk = 1'b1;
                        state_d = ST_BLOW;
                    end
                end
                ST_BLOW: begin
                    if (line_s)
                        state_d = cf0_en ? ST_CF0 : ST_CF1;
                end
                ST_CF0: begin
                    if (byte_valid) begin
                        if (byte_data == cf0_val) begin
                            evt.cf0 = 1'b1;
                            state_d = ST_CF1;
                        end else begin
                            state_d = restart;
                        end
                    end
                end
                ST_CF1: begin
                    if (byte_valid) begin
                        if (|cf1_hit) begin
                            evt.cf1 = 1'b1;
                            state_d = ST_PAY;
                        end else begin
                            state_d = restart;
                        end
                    end
                end
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign line_low_st = (state_q == ST_BLOW);
    assign payload_go  = (state_q == ST_PAY);

    AST_BLOW_LEAVES_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        (line_low_st && line_s) |=> !line_low_st); // R5

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt)); // R2

    AST_PAY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (payload_go && !arm) |=> payload_go); // R8
endmodule

// File: rtl/sfrm_flags.sv
module sfrm_flags
    import sfrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_FLAG-1:0] set_v,
    input  logic [N_FLAG-1:0] clr_v,
    input  logic [N_FLAG-1:0] ie_v,
    output logic [N_FLAG-1:0] flag_v,
    output logic [N_FLAG-1:0] irq_v
);
    for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_v[i] <= 1'b0;
                irq_v[i]  <= 1'b0;
            end else begin
                flag_v[i] <= (flag_v[i] & ~clr_v[i]) | set_v[i];
                irq_v[i]  <= set_v[i] & ie_v[i];
            end
        end

        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr_v[i] && !set_v[i]) |=> !flag_v[i]); // R10

        AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
            irq_v[i] |-> flag_v[i]); // R12
    end
endmodule

// File: rtl/sfrm_top.sv
module sfrm_top
    import sfrm_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              arm,
    input  logic              brk_en,
    input  logic              cf0_en,
    input  logic [CNT_W-1:0]  brk_count,
    input  logic [PRE_W-1:0]  brk_presc,
    input  logic [BYTE_W-1:0] cf0_val,
    input  logic [BYTE_W-1:0] cf1_pri,
    input  logic [BYTE_W-1:0] cf1_sec,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              ie_brk,
    input  logic              ie_cf0,
    input  logic              ie_cf1,
    input  logic [N_FLAG-1:0] flag_clr,
    output logic              flag_brk,
    output logic              flag_cf0,
    output logic              flag_cf1,
    output logic              irq_brk,
    output logic              irq_cf,
    output logic              line_low_st,
    output logic              payload_go
);
    logic             line_s;
    logic [CNT_W-1:0] low_cnt;
    sfrm_evt_t        evt;
    logic [N_FLAG-1:0] flag_v, irq_v;

    sfrm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rx_line),
        .dout(line_s)
    );

    sfrm_brk_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .line_s (line_s),
        .presc  (brk_presc),
        .low_cnt(low_cnt)
    );

    sfrm_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .brk_en     (brk_en),
        .cf0_en     (cf0_en),
        .line_s     (line_s),
        .low_cnt    (low_cnt),
        .brk_count  (brk_count),
        .cf0_val    (cf0_val),
        .cf1_pri    (cf1_pri),
        .cf1_sec    (cf1_sec),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .evt        (evt),
        .line_low_st(line_low_st),
        .payload_go (payload_go)
    );

    sfrm_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .set_v (evt),
        .clr_v (flag_clr),
        .ie_v  ({ie_cf1, ie_cf0, ie_brk}),
        .flag_v(flag_v),
        .irq_v (irq_v)
    );

    assign flag_brk = flag_v[0];
    assign flag_cf0 = flag_v[1];
    assign flag_cf1 = flag_v[2];
    assign irq_brk  = irq_v[0];
    assign irq_cf   = irq_v[1] | irq_v[2];

    AST_BRK_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_brk |=> !irq_brk); // R3

    AST_PAY_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(payload_go) |-> $past(byte_valid)); // R8

    AST_BRK_BEFORE_LOWST: assert property (@(posedge clk) disable iff (rst)
        $rose(line_low_st) |-> flag_brk); // R5
endmodule

// File: tb/sim_sfrm_top.sv
`timescale 1ns/1ps
module sim_sfrm_top;
    localparam int CNT_W = 8;
    localparam int PRE_W = 4;
    localparam int LC_MAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_line = 1'b1, arm = 1'b0, brk_en = 1'b1, cf0_en = 1'b1;
    logic [CNT_W-1:0] brk_count = 8'd4;
    logic [PRE_W-1:0] brk_presc = 4'd2;
    logic [7:0] cf0_val = 8'h55, cf1_pri = 8'hA1, cf1_sec = 8'h3C;
    logic byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic ie_brk = 1'b1, ie_cf0 = 1'b1, ie_cf1 = 1'b1;
    logic [2:0] flag_clr = 3'b000;
    logic flag_brk, flag_cf0, flag_cf1, irq_brk, irq_cf, line_low_st, payload_go;

    always #2.5 clk = ~clk;

    sfrm_top #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u0 (
        .clk(clk), .rst(rst), .rx_line(rx_line), .arm(arm), .brk_en(brk_en),
        .cf0_en(cf0_en), .brk_count(brk_count), .brk_presc(brk_presc),
        .cf0_val(cf0_val), .cf1_pri(cf1_pri), .cf1_sec(cf1_sec),
        .byte_valid(byte_valid), .byte_data(byte_data), .ie_brk(ie_brk),
        .ie_cf0(ie_cf0), .ie_cf1(ie_cf1), .flag_clr(flag_clr),
        .flag_brk(flag_brk), .flag_cf0(flag_cf0), .flag_cf1(flag_cf1),
        .irq_brk(irq_brk), .irq_cf(irq_cf), .line_low_st(line_low_st),
        .payload_go(payload_go)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    int n_irq_brk = 0;
    int n_irq_cf = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: states 0 idle,1 wait break,2 low held,3 byte0,4 byte1,5 payload
    int m_s1, m_s2, m_pc, m_lc, m_st;
    int m_fb, m_f0, m_f1, m_ib, m_ic;

    always @(posedge clk) begin
        int nst, start, eb, e0, e1;
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_pc = 0; m_lc = 0; m_st = 0;
            m_fb = 0; m_f0 = 0; m_f1 = 0; m_ib = 0; m_ic = 0;
        end else begin
            eb = 0; e0 = 0; e1 = 0; nst = m_st;
            start = brk_en ? 1 : (cf0_en ? 3 : 4);
            if (arm) nst = start;
            else if (m_st == 1) begin
                if (m_s2 == 0 && m_lc >= int'(brk_count)) begin nst = 2; eb = 1; end
            end else if (m_st == 2) begin
                if (m_s2 == 1) nst = cf0_en ? 3 : 4;
            end else if (m_st == 3) begin
                if (byte_valid) begin
                    if (byte_data == cf0_val) begin e0 = 1; nst = 4; end
                    else nst = start;
                end
            end else if (m_st == 4) begin
                if (byte_valid) begin
                    if (byte_data == cf1_pri || byte_data == cf1_sec) begin e1 = 1; nst = 5; end
                    else nst = start;
                end
            end
            if (m_s2 == 1) begin m_pc = 0; m_lc = 0; end
            else if (m_pc == int'(brk_presc)) begin
                m_pc = 0;
                if (m_lc < LC_MAX) m_lc++;
            end else m_pc++;
            m_s2 = m_s1; m_s1 = int'(rx_line);
            m_fb = ((m_fb != 0 && !flag_clr[0]) || eb != 0) ? 1 : 0;
            m_f0 = ((m_f0 != 0 && !flag_clr[1]) || e0 != 0) ? 1 : 0;
            m_f1 = ((m_f1 != 0 && !flag_clr[2]) || e1 != 0) ? 1 : 0;
            m_ib = (eb != 0 && ie_brk) ? 1 : 0;
            m_ic = ((e0 != 0 && ie_cf0) || (e1 != 0 && ie_cf1)) ? 1 : 0;
            m_st = nst;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R3 flag_brk", int'(flag_brk), m_fb);
            chk("R6 flag_cf0", int'(flag_cf0), m_f0);
            chk("R8 flag_cf1", int'(flag_cf1), m_f1);
            chk("R3 irq_brk", int'(irq_brk), m_ib);
            chk("R12 irq_cf", int'(irq_cf), m_ic);
            chk("R5 line_low_st", int'(line_low_st), (m_st == 2) ? 1 : 0);
            chk("R8 payload_go", int'(payload_go), (m_st == 5) ? 1 : 0);
            if (irq_brk) n_irq_brk++;
            if (irq_cf) n_irq_cf++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_arm();
        arm = 1'b1; @(negedge clk); arm = 1'b0; idle(2);
    endtask

    task automatic send(input logic [7:0] b);
        byte_valid = 1'b1; byte_data = b; @(negedge clk);
        byte_valid = 1'b0; idle(3);
    endtask

    task automatic brk(input int n);
        rx_line = 1'b0; idle(n); rx_line = 1'b1; idle(5);
    endtask

    task automatic clear_all();
        flag_clr = 3'b111; @(negedge clk); flag_clr = 3'b000; idle(1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int b0, c0;
        idle(1);
        cmp_on = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1: reset values and idle until arm
        chk("R1 flags", int'({flag_brk, flag_cf0, flag_cf1}), 0);
        chk("R1 outputs", int'({irq_brk, irq_cf, line_low_st, payload_go}), 0);
        send(8'h55); send(8'hA1); brk(20);
        chk("R1 idle ignores", int'({flag_brk, flag_cf0, payload_go}), 0);

        // full frame, primary byte
        b0 = n_irq_brk; c0 = n_irq_cf;
        do_arm();
        rx_line = 1'b0; idle(20);
        chk("R3 break flagged", int'(flag_brk), 1);
        chk("R5 low status held", int'(line_low_st), 1);
        send(8'h55);
        chk("R11 byte during low ignored", int'(flag_cf0), 0);
        rx_line = 1'b1; idle(5);
        chk("R5 low status cleared", int'(line_low_st), 0);
        send(8'h55);
        chk("R6 byte0 matched", int'(flag_cf0), 1);
        send(8'hA1);
        chk("R8 payload primary", int'(payload_go), 1);
        chk("R3 irq_brk count", n_irq_brk - b0, 1);
        chk("R6 irq_cf count", n_irq_cf - c0, 2);
        send(8'h55);
        chk("R11 byte in payload ignored", int'(payload_go), 1);

        // R10 clear
        clear_all();
        chk("R10 flags cleared", int'({flag_brk, flag_cf0, flag_cf1}), 0);

        // R4 short lows do not accumulate
        do_arm();
        for (int k = 0; k < 4; k++) begin
            rx_line = 1'b0; idle(8); rx_line = 1'b1; idle(1);
        end
        idle(4);
        chk("R4 no break from short lows", int'(flag_brk), 0);

        // R11 bytes while awaiting break
        send(8'h55); send(8'hA1);
        chk("R11 bytes before break", int'({flag_cf0, payload_go}), 0);

        // R7 byte0 mismatch
        brk(20);
        send(8'h12);
        chk("R7 no flag on mismatch", int'(flag_cf0), 0);
        send(8'hA1);
        chk("R7 falls back", int'(payload_go), 0);

        // R9 byte1 mismatch, then secondary value
        clear_all();
        brk(20); send(8'h55); send(8'h77);
        chk("R9 no flag1", int'(flag_cf1), 0);
        send(8'h55); send(8'h3C);
        chk("R9 needs new break", int'(payload_go), 0);
        brk(20); send(8'h55); send(8'h3C);
        chk("R8 payload secondary", int'(payload_go), 1);

        // R2 frame shapes
        brk_en = 1'b0; cf0_en = 1'b0; do_arm();
        chk("R2 arm drops payload", int'(payload_go), 0);
        send(8'hA1);
        chk("R2 byte1 only", int'(payload_go), 1);
        cf0_en = 1'b1; do_arm(); send(8'h55); send(8'h3C);
        chk("R2 byte0 and byte1", int'(payload_go), 1);
        brk_en = 1'b1; cf0_en = 1'b0; do_arm(); brk(20); send(8'hA1);
        chk("R2 break and byte1", int'(payload_go), 1);

        // R12 masked interrupts
        clear_all();
        ie_brk = 1'b0; ie_cf0 = 1'b0; ie_cf1 = 1'b0; cf0_en = 1'b1;
        b0 = n_irq_brk; c0 = n_irq_cf;
        do_arm(); brk(20); send(8'h55); send(8'hA1);
        chk("R12 no irqs", (n_irq_brk - b0) + (n_irq_cf - c0), 0);
        chk("R12 flags still set", int'({flag_brk, flag_cf0, flag_cf1}), 7);

        // R3 saturating long break with largest count
        clear_all();
        brk_count = 8'd255; brk_presc = 4'd0; do_arm();
        rx_line = 1'b0; idle(300);
        chk("R3 long break detected", int'(flag_brk), 1);
        rx_line = 1'b1; idle(5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule